// File: doc/BRIEF.md
# Register swap bus controller

This block exchanges the contents of two registers that share a single data bus with a third register. A small controller steps through three bus transfers. First the second register is parked in the third. Next the first register is moved into the second. Last the parked value is moved into the first. In every cycle exactly one register, or none, drives the bus. The bus is modelled as a multiplexer steered by the per-register output enables, so there are no tri-state nets.

A swap is requested by sampling `start` high while the controller is idle. The controller then runs its three steps back to back and returns to idle on its own. A completion flag marks the last step. The registers can be loaded from outside through a plain write port. That port takes effect only while the controller is idle. Control and status pins are plain levels. There is no streaming interface, so no valid/ready or back-pressure rules apply.

A parameter selects the state encoding: either two binary state bits or four one-hot flip-flops. The behaviour at the ports is identical for both.

Top module: `swap_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the controller is idle: `oe`=0, `ie`=0 and `done`=0.
- R2: While idle with `start` sampled low, the controller stays idle and no enable is asserted.
- R3: A rising clock edge that samples `start`=1 in idle begins three consecutive steps. The step 2→3 has `oe`=3'b010 and `ie`=3'b100. The step 1→2 has `oe`=3'b001 and `ie`=3'b010. The step 3→1 has `oe`=3'b100 and `ie`=3'b001. Bit 0 is register 1, bit 1 is register 2 and bit 2 is register 3.
- R4: `done` is high exactly during the 3→1 step, for one cycle per swap.
- R5: At most one bit of `oe` is high in any cycle. `bus_q` equals the enabled register, or zero when `oe`=0.
- R6: A register whose `ie` bit is high in a cycle takes the `bus_q` value of that cycle at the next rising edge. After a swap, register 1 and register 2 are exchanged and register 3 holds the old register 2.
- R7: After the 3→1 step the controller returns to idle for at least one cycle, whatever `start` is. `start` is ignored during the steps, and a held `start` begins a new swap from idle.
- R8: A `pre_we` bit writes `pre_data` into its register at the next edge only while idle. Outside idle it is ignored.
- R9: Parameter `ONE_HOT`=1 selects four one-hot state flip-flops and 0 selects two binary state bits. Port behaviour is the same for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Swap request, sampled in idle |
| pre_we | input | 3 | Per-register external write enable (bit 0 = register 1) |
| pre_data | input | W | External write data |
| oe | output | 3 | Per-register bus output enable |
| ie | output | 3 | Per-register load enable from the bus |
| done | output | 1 | High during the final transfer step |
| bus_q | output | W | Shared bus value |
| r1_q | output | W | Register 1 contents |
| r2_q | output | W | Register 2 contents |
| r3_q | output | W | Register 3 contents |

## Verification
The assertions assume that `start` and `pre_we` are stable around the rising edge. They also assume that reset is held for at least one edge before any check applies. The bench meets this by driving every input on the falling edge and holding reset low for several cycles. The exchange check assumes that nothing writes the registers externally during a swap. The bench only drives `pre_we` mid-swap in the scenario that shows those writes are ignored. Both encodings are instantiated side by side on the same stimulus, so every port check applies to each of them.

// File: rtl/swap_pkg.sv
package swap_pkg;
  localparam int NREG = 3;

  typedef enum logic [1:0] {
    BST_IDLE = 2'b00,
    BST_P23  = 2'b01,
    BST_P12  = 2'b10,
    BST_P31  = 2'b11
  } bin_state_e;
endpackage

// File: rtl/swap_fsm.sv
module swap_fsm
  import swap_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            idle,
  output logic [NREG-1:0] oe,
  output logic [NREG-1:0] ie,
  output logic            done
);
  logic st_p23, st_p12, st_p31;

  generate
    if (ONE_HOT) begin : g_onehot
      logic [3:0] hot_q;
      always_ff @(posedge clk) begin
        if (!rst_n) hot_q <= 4'b0001;
        else begin
          hot_q[0] <= (~start & hot_q[0]) | hot_q[3];
          hot_q[1] <= start & hot_q[0];
          hot_q[2] <= hot_q[1];
          hot_q[3] <= hot_q[2];
        end
      end
      assign idle   = hot_q[0];
      assign st_p23 = hot_q[1];
      assign st_p12 = hot_q[2];
      assign st_p31 = hot_q[3];

      // R9
      hot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hot_q) == 1);
    end else begin : g_binary
      bin_state_e cur_q, nxt;
      always_comb begin
        unique case (cur_q)
          BST_IDLE: nxt = start ? BST_P23 : BST_IDLE;
          BST_P23:  nxt = BST_P12;
          BST_P12:  nxt = BST_P31;
          default:  nxt = BST_IDLE;
        endcase
      end
      always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= BST_IDLE;
        else        cur_q <= nxt;
      end
      assign idle   = ~cur_q[1] & ~cur_q[0];
      assign st_p23 = ~cur_q[1] &  cur_q[0];
      assign st_p12 =  cur_q[1] & ~cur_q[0];
      assign st_p31 =  cur_q[1] &  cur_q[0];
    end
  endgenerate

  assign oe   = {st_p31, st_p23, st_p12};
  assign ie   = {st_p23, st_p12, st_p31};
  assign done = st_p31;

  // R5
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe));
  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe == 3'b010) |=> (oe == 3'b001 && ie == 3'b010));
  // R7
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idle && oe == 3'b000 && !done));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> idle);
endmodule

// File: rtl/swap_regfile.sv
module swap_regfile
  import swap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] ld,
  input  logic [W-1:0]    bus_d,
  input  logic [NREG-1:0] wr,
  input  logic [W-1:0]    wr_d,
  output logic [W-1:0]    q [NREG]
);
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)     q[i] <= '0;
        else if (ld[i]) q[i] <= bus_d;
        else if (wr[i]) q[i] <= wr_d;
      end

      // R6
      bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld[i] |=> (q[i] == $past(bus_d)));
    end
  endgenerate
endmodule

// File: rtl/swap_bus_mux.sv
module swap_bus_mux
  import swap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] sel,
  input  logic [W-1:0]    src [NREG],
  output logic [W-1:0]    bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NREG; i++)
      bus = bus | (src[i] & {W{sel[i]}});
  end

  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (bus == '0));
endmodule

// File: rtl/swap_bus_ctrl.sv
module swap_bus_ctrl
  import swap_pkg::*;
#(
  parameter int W       = 16,
  parameter bit ONE_HOT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   pre_we,
  input  logic [W-1:0] pre_data,
  output logic [2:0]   oe,
  output logic [2:0]   ie,
  output logic         done,
  output logic [W-1:0] bus_q,
  output logic [W-1:0] r1_q,
  output logic [W-1:0] r2_q,
  output logic [W-1:0] r3_q
);
  logic            idle;
  logic [NREG-1:0] wr_gated;
  logic [W-1:0]    regs [NREG];

  swap_fsm #(.ONE_HOT(ONE_HOT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .idle(idle), .oe(oe), .ie(ie), .done(done)
  );

  assign wr_gated = pre_we & {NREG{idle}};

  swap_regfile #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld(ie), .bus_d(bus_q),
    .wr(wr_gated), .wr_d(pre_data), .q(regs)
  );

  swap_bus_mux #(.W(W)) u_bus (
    .clk(clk), .rst_n(rst_n), .sel(oe), .src(regs), .bus(bus_q)
  );

  assign r1_q = regs[0];
  assign r2_q = regs[1];
  assign r3_q = regs[2];

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && pre_we[1] && !ie[1]) |=> $stable(r2_q));
  // R5
  bus_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe == 3'b100) |-> (bus_q == r3_q));
endmodule

// File: tb/swap_bus_ctrl_test.sv
`timescale 1ns/1ps
module swap_bus_ctrl_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] pre_we = 3'b000;
  logic [W-1:0] pre_data = '0;

  logic [2:0] oe_h, ie_h, oe_b, ie_b;
  logic done_h, done_b;
  logic [W-1:0] bus_h, bus_b, a1, a2, a3, b1, b2, b3;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [W-1:0] e1, e2, e3;

  always #4 clk = ~clk;

  swap_bus_ctrl #(.W(W), .ONE_HOT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_we(pre_we), .pre_data(pre_data),
    .oe(oe_h), .ie(ie_h), .done(done_h), .bus_q(bus_h),
    .r1_q(a1), .r2_q(a2), .r3_q(a3));

  swap_bus_ctrl #(.W(W), .ONE_HOT(1'b0)) uut_bin (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_we(pre_we), .pre_data(pre_data),
    .oe(oe_b), .ie(ie_b), .done(done_b), .bus_q(bus_b),
    .r1_q(b1), .r2_q(b2), .r3_q(b3));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // control outputs of both encodings against the expectation (R9)
  task automatic chk_ctl(input string req, input logic [2:0] oe_e,
                         input logic [2:0] ie_e, input logic done_e,
                         input logic [W-1:0] bus_e);
    chk({oe_h, ie_h, done_h, bus_h} == {oe_e, ie_e, done_e, bus_e},
        {req, " one-hot"}, {oe_h, ie_h, done_h, bus_h}, {oe_e, ie_e, done_e, bus_e});
    chk({oe_b, ie_b, done_b, bus_b} == {oe_e, ie_e, done_e, bus_e},
        {req, " binary R9"}, {oe_b, ie_b, done_b, bus_b}, {oe_e, ie_e, done_e, bus_e});
  endtask

  task automatic chk_regs(input string req);
    chk({a1, a2, a3} == {e1, e2, e3}, {req, " one-hot"}, {a1, a2, a3}, {e1, e2, e3});
    chk({b1, b2, b3} == {e1, e2, e3}, {req, " binary R9"}, {b1, b2, b3}, {e1, e2, e3});
  endtask

  task automatic preload(input logic [W-1:0] v1, input logic [W-1:0] v2,
                         input logic [W-1:0] v3);
    pre_we = 3'b001; pre_data = v1; @(negedge clk);
    pre_we = 3'b010; pre_data = v2; @(negedge clk);
    pre_we = 3'b100; pre_data = v3; @(negedge clk);
    pre_we = 3'b000;
    e1 = v1; e2 = v2; e3 = v3;
    chk_regs("R8 idle preload");
  endtask

  // one swap; start pulsed for one cycle unless hold is set
  task automatic run_swap(input bit hold, input bit poke);
    logic [W-1:0] o1, o2;
    o1 = e1; o2 = e2;
    start = 1'b1; @(negedge clk);
    if (!hold) start = 1'b0;
    chk_ctl("R3 step 2to3", 3'b010, 3'b100, 1'b0, o2);
    @(negedge clk);
    chk_ctl("R3 step 1to2", 3'b001, 3'b010, 1'b0, o1);
    if (poke) begin pre_we = 3'b110; pre_data = 16'hDEAD; end
    @(negedge clk);
    chk_ctl("R4 step 3to1 done", 3'b100, 3'b001, 1'b1, o2);
    if (poke) begin pre_we = 3'b110; pre_data = 16'hBEEF; end
    @(negedge clk);
    pre_we = 3'b000;
    chk_ctl("R7 idle after done", 3'b000, 3'b000, 1'b0, '0);
    e1 = o2; e2 = o1; e3 = o2;
    chk_regs(poke ? "R8 busy write ignored" : "R6 exchanged");
  endtask

  task automatic t_reset;
    chk_ctl("R1 in reset", 3'b000, 3'b000, 1'b0, '0);
    rst_n = 1'b1; @(negedge clk);
    chk_ctl("R1 after reset", 3'b000, 3'b000, 1'b0, '0);
  endtask

  task automatic t_idle_hold;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_ctl("R2 idle hold", 3'b000, 3'b000, 1'b0, '0);
    end
    chk_regs("R2 regs untouched");
  endtask

  task automatic t_basic;
    preload(16'h1111, 16'h2222, 16'h3333);
    run_swap(1'b0, 1'b0);
    preload(16'hA5A5, 16'h0000, 16'hFFFF);
    run_swap(1'b0, 1'b0);
    preload(16'h8001, 16'h7FFE, 16'h1234);
    run_swap(1'b0, 1'b0);
  endtask

  task automatic t_held_start;
    preload(16'hCAFE, 16'hF00D, 16'h0101);
    run_swap(1'b1, 1'b0);
    @(negedge clk);
    start = 1'b0;
    chk_ctl("R7 held start re-enters step 2to3", 3'b010, 3'b100, 1'b0, e2);
    @(negedge clk); @(negedge clk); @(negedge clk);
    e1 = 16'hCAFE; e2 = 16'hF00D; e3 = 16'hCAFE;
    chk_regs("R7 second swap restores");
    chk_ctl("R7 idle after second", 3'b000, 3'b000, 1'b0, '0);
  endtask

  task automatic t_busy_write;
    preload(16'h0A0A, 16'h0B0B, 16'h0C0C);
    run_swap(1'b0, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    e1 = '0; e2 = '0; e3 = '0;
    t_idle_hold();
    t_basic();
    t_held_start();
    t_busy_write();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule